// File: doc/BRIEF.md
# DC/DC converter power-up mode sequencer

This block steps a switching regulator controller from off to full regulation. It moves through four modes: disable, idle, soft-start and normal. Two enable inputs are used, a pin enable and a register enable bit, and both must be high for the converter to run. Each enable passes through a two-flop synchronizer first. Once both are high, the sequencer waits a fixed number of oscillator ticks in idle so the analog circuits can settle. It then raises a digital reference code from zero towards the setpoint code, one step per oscillator tick. When the reference reaches the setpoint, it enters normal mode and enables the current-limit and short-circuit protections.

While disabled, the block drives a fixed switch pattern that pulls the output towards ground. The four output switches carry no regulation drive, the protections are masked and the reference is held at zero. If either enable drops, in any mode, the block returns to disable and clears its counters. A later enable therefore always starts again with the full idle delay and a ramp from zero.

Top module: `dcdc_seq_top`

## Requirements
- R1: The block leaves disable only when the synchronized pin enable and register enable are both high. Mode codes: 0 = disable, 1 = idle, 2 = soft-start, 3 = normal.
- R2: A change on an enable input reaches the mode register on the third rising clock edge after the change. The first two edges fill the synchronizer.
- R3: In disable, `sw_force` = 4'b0110 (bit0 input-leg high side, bit1 input-leg low side, bit2 output-leg high side, bit3 output-leg low side). Also `gate_en` = 0, `prot_en` = 0 and `ref_code` = 0.
- R4: In idle, `gate_en` and `sw_force` are both 0. The block moves to soft-start on the edge that registers the IDLE_TICKS-th oscillator tick, and not on any earlier tick.
- R5: In soft-start, `gate_en` = 4'b1111 and `prot_en` = 0. `ref_code` starts at 0 and rises by exactly one on each edge that samples `osc_tick` high.
- R6: In soft-start, once `ref_code` >= `target`, the next clock edge enters normal. `ss_done` and `prot_en` are high exactly in normal mode.
- R7: In normal mode, `ref_code` follows `target` with one cycle of delay.
- R8: If either enable drops, the block returns to disable from any mode and clears the idle count and the reference. The next start needs the full IDLE_TICKS again.
- R9: Either enable can start the sequence by rising while the other is already high.
- R10: After reset, the block is in disable with the R3 outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_pin | input | 1 | Pin enable, asynchronous |
| en_reg | input | 1 | Register enable bit, asynchronous |
| osc_tick | input | 1 | One-cycle pulse from the internal oscillator |
| target | input | REF_W | Setpoint code for the reference |
| mode | output | 2 | Current mode (R1 codes) |
| gate_en | output | 4 | Regulation drive enable per output switch |
| sw_force | output | 4 | Forced-on discharge pattern per switch |
| prot_en | output | 1 | Current-limit and short-circuit protection enable |
| ref_code | output | REF_W | Ramped reference code |
| ss_done | output | 1 | Soft-start complete |

## Verification
The hardest cases to reach are an enable dropping partway through the idle count or the ramp, and the restart that follows. They need a precise number of oscillator ticks delivered after a synchronized enable. The bench drives every tick as a single-cycle pulse and counts them itself. It aborts the sequence at chosen tick counts, then re-enables through the other input and checks that one tick short of the full idle delay still leaves the block in idle. The ramp is swept over several setpoints, including zero and full scale, and the reference is compared after every tick.

// File: rtl/dcdc_seq_pkg.sv
package dcdc_seq_pkg;
    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_IDLE = 2'd1,
        MODE_SOFT = 2'd2,
        MODE_RUN  = 2'd3
    } mode_e;

    localparam logic [3:0] PULLDOWN_PAT = 4'b0110;
    localparam logic [3:0] ALL_GATES    = 4'b1111;
endpackage

// File: rtl/dcdc_en_sync.sv
module dcdc_en_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/dcdc_out_dec.sv
module dcdc_out_dec
    import dcdc_seq_pkg::*;
(
    input  mode_e      mode,
    output logic [3:0] gate_en,
    output logic [3:0] sw_force,
    output logic       prot_en,
    output logic       ss_done
);
    always_comb begin
        gate_en  = '0;
        sw_force = '0;
        prot_en  = 1'b0;
        ss_done  = 1'b0;
        unique case (mode)
            MODE_OFF:  sw_force = PULLDOWN_PAT;
            MODE_IDLE: ;
            MODE_SOFT: gate_en = ALL_GATES;
            MODE_RUN: begin
                gate_en = ALL_GATES;
                prot_en = 1'b1;
                ss_done = 1'b1;
            end
            default: sw_force = PULLDOWN_PAT;
        endcase
    end
endmodule

// File: rtl/dcdc_seq_top.sv
module dcdc_seq_top
    import dcdc_seq_pkg::*;
#(
    parameter int IDLE_TICKS  = 50,
    parameter int REF_W       = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_pin,
    input  logic             en_reg,
    input  logic             osc_tick,
    input  logic [REF_W-1:0] target,
    output logic [1:0]       mode,
    output logic [3:0]       gate_en,
    output logic [3:0]       sw_force,
    output logic             prot_en,
    output logic [REF_W-1:0] ref_code,
    output logic             ss_done
);
    localparam int CNT_W = (IDLE_TICKS > 1) ? $clog2(IDLE_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_TICKS - 1);

    typedef struct packed {
        mode_e            mode;
        logic [CNT_W-1:0] idle_cnt;
        logic [REF_W-1:0] ref_val;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [1:0] en_sync;
    logic       en_ok;

    dcdc_en_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({en_reg, en_pin}),
        .sync_out (en_sync)
    );

    assign en_ok = en_sync[0] & en_sync[1];

    always_comb begin
        st_d = st_q;
        if (!en_ok) begin
            st_d.mode     = MODE_OFF;
            st_d.idle_cnt = '0;
            st_d.ref_val  = '0;
        end else begin
            unique case (st_q.mode)
                MODE_OFF: begin
                    st_d.mode     = MODE_IDLE;
                    st_d.idle_cnt = '0;
                    st_d.ref_val  = '0;
                end
                MODE_IDLE: begin
                    if (osc_tick) begin
                        if (st_q.idle_cnt == CNT_LAST) begin
                            st_d.mode     = MODE_SOFT;
                            st_d.idle_cnt = '0;
                            st_d.ref_val  = '0;
                        end else begin
                            st_d.idle_cnt = st_q.idle_cnt + 1'b1;
                        end
                    end
                end
                MODE_SOFT: begin
                    if (st_q.ref_val >= target) begin
                        st_d.mode = MODE_RUN;
                    end else if (osc_tick) begin
                        st_d.ref_val = st_q.ref_val + 1'b1;
                    end
                end
                MODE_RUN: begin
                    st_d.ref_val = target;
                end
                default: st_d.mode = MODE_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_OFF, idle_cnt: '0, ref_val: '0};
        end else begin
            st_q <= st_d;
        end
    end

    dcdc_out_dec u_dec (
        .mode     (st_q.mode),
        .gate_en  (gate_en),
        .sw_force (sw_force),
        .prot_en  (prot_en),
        .ss_done  (ss_done)
    );

    assign mode     = st_q.mode;
    assign ref_code = st_q.ref_val;
endmodule

// File: rtl/dcdc_seq_chk.sv
module dcdc_seq_chk #(
    parameter int REF_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_ok,
    input logic [1:0]       mode,
    input logic [3:0]       gate_en,
    input logic [3:0]       sw_force,
    input logic             prot_en,
    input logic [REF_W-1:0] ref_code,
    input logic             ss_done
);
    assert_off_on_enable_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_ok |=> mode == 2'd0);

    assert_off_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'd0 |-> (sw_force == 4'b0110 && gate_en == 4'b0000 && ref_code == '0 && !prot_en));

    assert_soft_only_from_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && $past(mode) != 2'd2) |-> $past(mode) == 2'd1);

    assert_ramp_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && $past(mode) == 2'd2) |->
        (ref_code == $past(ref_code) || ref_code == REF_W'($past(ref_code) + 1'b1)));

    assert_prot_after_soft_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_en) |-> ($past(mode) == 2'd2 && ss_done));

    assert_start_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && $past(mode) == 2'd0) |-> $past(en_ok));
endmodule

bind dcdc_seq_top dcdc_seq_chk #(.REF_W(REF_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_ok    (en_ok),
    .mode     (mode),
    .gate_en  (gate_en),
    .sw_force (sw_force),
    .prot_en  (prot_en),
    .ref_code (ref_code),
    .ss_done  (ss_done)
);

// File: tb/dcdc_seq_top_test.sv
module dcdc_seq_top_test;
    localparam int IDLE_TICKS = 50;
    localparam int REF_W      = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en_pin = 1'b0;
    logic             en_reg = 1'b0;
    logic             osc_tick = 1'b0;
    logic [REF_W-1:0] target = '0;
    logic [1:0]       mode;
    logic [3:0]       gate_en;
    logic [3:0]       sw_force;
    logic             prot_en;
    logic [REF_W-1:0] ref_code;
    logic             ss_done;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dcdc_seq_top #(.IDLE_TICKS(IDLE_TICKS), .REF_W(REF_W)) uut (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .en_reg(en_reg),
        .osc_tick(osc_tick), .target(target), .mode(mode), .gate_en(gate_en),
        .sw_force(sw_force), .prot_en(prot_en), .ref_code(ref_code), .ss_done(ss_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic tick();
        osc_tick = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_off(input string req);
        chk_eq({req, " mode"}, mode, 0);
        chk_eq({req, " sw_force"}, sw_force, 4'b0110);
        chk_eq({req, " gate_en"}, gate_en, 0);
        chk_eq({req, " prot_en"}, prot_en, 0);
        chk_eq({req, " ref_code"}, ref_code, 0);
        chk_eq({req, " ss_done"}, ss_done, 0);
    endtask

    // From disable with both enables high: idle, full delay, then ramp to tgt.
    task automatic run_to_normal(input int tgt);
        target = REF_W'(tgt);
        chk_eq("R1 idle entered", mode, 1);
        for (int k = 1; k < IDLE_TICKS; k++) begin
            tick();
            chk_eq("R4 still idle", mode, 1);
        end
        chk_eq("R4 idle gate_en", gate_en, 0);
        chk_eq("R4 idle sw_force", sw_force, 0);
        tick();
        chk_eq("R4 soft after full delay", mode, 2);
        chk_eq("R5 soft gate_en", gate_en, 4'b1111);
        chk_eq("R5 ref starts at zero", ref_code, 0);
        for (int k = 1; k <= tgt; k++) begin
            tick();
            chk_eq("R5 ramp step", ref_code, k);
            chk_eq("R5 still soft", mode, 2);
            chk_eq("R5 prot masked", prot_en, 0);
        end
        @(negedge clk);
        chk_eq("R6 normal entered", mode, 3);
        chk_eq("R6 ss_done", ss_done, 1);
        chk_eq("R6 prot_en", prot_en, 1);
        chk_eq("R6 ref at target", ref_code, tgt);
    endtask

    initial begin
        int tgts [5] = '{0, 1, 3, 17, 511};
        repeat (3) @(negedge clk);
        chk_off("R10 reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_off("R10 after release");

        // R1: one enable alone never starts.
        en_pin = 1'b1;
        settle();
        repeat (5) tick();
        chk_off("R1 pin only");
        en_pin = 1'b0;
        en_reg = 1'b1;
        settle();
        repeat (5) tick();
        chk_off("R1 reg only");

        // R2 / R9: pin rises with reg already high; timing through synchronizer.
        en_pin = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk_eq("R2 no change after two edges", mode, 0);
        @(negedge clk);
        chk_eq("R2 R9 idle on third edge", mode, 1);

        for (int t = 0; t < 5; t++) begin
            run_to_normal(tgts[t]);
            // R7: reference follows target in normal.
            target = REF_W'((tgts[t] * 7 + 5) % 512);
            @(negedge clk);
            chk_eq("R7 ref follows target", ref_code, (tgts[t] * 7 + 5) % 512);
            // R8: drop alternating enable.
            if (t % 2 == 0) en_reg = 1'b0; else en_pin = 1'b0;
            repeat (2) @(posedge clk);
            @(negedge clk);
            chk_eq("R2 drop delay", mode, 3);
            @(negedge clk);
            chk_off("R8 drop from normal");
            // R9: restart by the dropped input, abort in idle partway.
            if (t % 2 == 0) en_reg = 1'b1; else en_pin = 1'b1;
            settle();
            chk_eq("R9 restart by either enable", mode, 1);
            repeat (10 + t * 7) tick();
            en_pin = 1'b0;
            settle();
            chk_off("R8 drop in idle");
            en_pin = 1'b1;
            settle();
            // Full delay needed again; then abort during soft.
            for (int k = 1; k < IDLE_TICKS; k++) tick();
            chk_eq("R8 idle count restarted", mode, 1);
            tick();
            chk_eq("R8 soft after full delay", mode, 2);
            target = REF_W'(511);
            repeat (t + 2) tick();
            chk_eq("R5 partial ramp", ref_code, t + 2);
            en_reg = 1'b0;
            settle();
            chk_off("R8 drop in soft");
            en_reg = 1'b1;
            settle();
        end

        // R6: target lowered below reference during soft.
        for (int k = 0; k < IDLE_TICKS; k++) tick();
        target = REF_W'(100);
        repeat (8) tick();
        target = REF_W'(4);
        @(negedge clk);
        chk_eq("R6 lowered target ends soft", mode, 3);
        @(negedge clk);
        chk_eq("R7 ref snaps to target", ref_code, 4);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule